// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog for a host I/O bus. A 24-bit down-counter takes its start value from a programmable reload register. It loses one count per period of a slow 32.768 kHz reference, so one count is about 30.52 µs and the full 24-bit range is about 512 s. The slow reference enters asynchronously. It is synchronized into the system clock domain, and only its rising edge is used.

If software does not restart the count in time, the watchdog expires in two stages. The first zero crossing sets a first-stage flag and raises the interrupt. The counter then reloads itself to time a second period. A second zero crossing with no restart in between sets a second-stage flag. Depending on a control bit, that second crossing either raises the interrupt again or drives a module-reset pulse of fixed length.

Software restarts the count by writing any value to the count register. If the POST-port option is enabled, a write of any value to address 80h restarts it too. The bench drives the block in the usual order: stop, program the reload value, restart, then run.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After a synchronous reset, the control register (0x00) reads 0, the reload register (0x04) reads 0, the count (0x08) reads 0 and the status (0x0C) reads 0. Both `irq_o` and `mod_rst_o` are low, and the counter does not move on reference edges.
- R2: While the run bit (control bit 0) is 1, each rising edge of `tick_in` lowers the count by one. While the run bit is 0, the count holds and no flag or interrupt is produced.
- R3: A write of any data to address 0x08 copies the reload register into the count, whatever the run bit is.
- R4: A write to address 0x80 restarts the count like R3 only when control bit 2 is 1. Otherwise it leaves the count unchanged.
- R5: A reference edge that finds the count at 1 or 0 while running is an expiry, and the count reloads from the reload register. The first expiry since the last restart sets status bit 0, which drives `irq_o` high.
- R6: An expiry that follows an earlier expiry, with no restart in between, sets status bit 1. When control bit 1 (auto-reset) is 0, status bit 1 drives `irq_o` high.
- R7: When control bit 1 is 1, a second-stage expiry drives `mod_rst_o` high for exactly `RST_PULSE_CLKS` system clocks. In that case status bit 1 does not drive `irq_o`.
- R8: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged. `irq_o` equals status bit 0 OR (status bit 1 AND NOT control bit 1).
- R9: The control register reads back bits 2:0 as written. The reload register reads back the low 24 bits as written. Address 0x08 reads the live count.
- R10: A restart clears the stage, so the next expiry after it counts as a first expiry again.
- R11: Further expiries after a second-stage expiry, with no restart, stay second-stage: status bit 1 is set again and, with auto-reset on, a new reset pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_in | input | 1 | Asynchronous 32.768 kHz reference |
| irq_o | output | 1 | Watchdog interrupt (level) |
| mod_rst_o | output | 1 | Module-reset pulse |

## Verification
The counting path gets three kinds of reload value. Reload values of 0 and 1 exercise the expiry-at-one-or-zero rule and the back-to-back two-stage sequence. Small values of 2 to 6 separate a plain decrement from an expiry tick. All-ones and oversized writes show that the reload register is 24 bits wide. Random mixes of reference edges, restarts through both addresses, control changes and status clears run against a bench model. These mixes tell a correct stage reset on restart (R10) apart from a stage that stays stuck. They also check that the interrupt follows the auto-reset bit, and that a POST-port write is ignored unless enabled. Directed cases measure the exact reset-pulse width and confirm that a stopped counter holds its value across reference edges.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] A_INIT = 8'h04;
    localparam logic [ADDR_W-1:0] A_CURR = 8'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] A_POST = 8'h80;

    // control register: bit 0 run, bit 1 auto-reset, bit 2 POST-port kick enable
    typedef struct packed {
        logic post_en;
        logic auto_rst;
        logic run;
    } ctrl_t;

    // status register: bit 0 first stage, bit 1 second stage
    typedef struct packed {
        logic second;
        logic first;
    } stat_t;

    typedef struct packed {
        logic kick;
        logic ctrl_we;
        logic init_we;
        logic stat_we;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic wr,
                                             input logic [ADDR_W-1:0] addr,
                                             input logic post_en);
        wr_dec_t d;
        d.kick    = wr && ((addr == A_CURR) || ((addr == A_POST) && post_en));
        d.ctrl_we = wr && (addr == A_CTRL);
        d.init_we = wr && (addr == A_INIT);
        d.stat_we = wr && (addr == A_STAT);
        return d;
    endfunction

    // Flag update: a new event wins over a simultaneous write-one-to-clear.
    function automatic logic next_flag(input logic cur, input logic set,
                                       input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/wdt2_tick_sync.sv
module wdt2_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_async,
    output logic tick_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= tick_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign tick_pulse = sync_q[LAST] & ~prev_q;

    // a rising edge of the reference yields a single-cycle pulse (R2)
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/wdt2_core.sv
module wdt2_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             kick,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             first_exp,
    output logic             second_exp
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             stage_q;
    logic             step;
    logic             at_end;

    always_comb begin
        step       = tick && run && !kick;
        at_end     = (cnt_q <= ONE);
        first_exp  = step && at_end && !stage_q;
        second_exp = step && at_end && stage_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            stage_q <= 1'b0;
        end else if (kick) begin
            cnt_q   <= init_val;
            stage_q <= 1'b0;
        end else if (step) begin
            if (at_end) begin
                cnt_q   <= init_val;
                stage_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign count = cnt_q;

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !kick) |=> $stable(count));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !kick && count > ONE) |=> count == $past(count) - ONE);

    assert_kick_load_R3: assert property (@(posedge clk) disable iff (rst)
        kick |=> count == $past(init_val));

    assert_stage_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        kick |=> !second_exp);

    assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({first_exp, second_exp}));

endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_first,
    input  logic              set_second,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output stat_t             stat,
    output logic [CNT_W-1:0]  init_val,
    output logic              kick,
    output logic [DATA_W-1:0] rdata
);
    ctrl_t            ctrl_q;
    stat_t            stat_q;
    logic [CNT_W-1:0] init_q;
    wr_dec_t          dec;

    always_comb dec = decode_write(wr, addr, ctrl_q.post_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            init_q <= '0;
            stat_q <= '0;
        end else begin
            if (dec.ctrl_we) ctrl_q <= ctrl_t'(wdata[2:0]);
            if (dec.init_we) init_q <= wdata[CNT_W-1:0];
            stat_q.first  <= next_flag(stat_q.first,  set_first,
                                       dec.stat_we && wdata[0]);
            stat_q.second <= next_flag(stat_q.second, set_second,
                                       dec.stat_we && wdata[1]);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = DATA_W'(ctrl_q);
            A_INIT:  rdata = DATA_W'(init_q);
            A_CURR:  rdata = DATA_W'(count);
            A_STAT:  rdata = DATA_W'(stat_q);
            default: rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign stat     = stat_q;
    assign init_val = init_q;
    assign kick     = dec.kick;

    assert_w1c_first_R8: assert property (@(posedge clk) disable iff (rst)
        (dec.stat_we && wdata[0] && !set_first) |=> !stat.first);

    assert_w1c_second_R8: assert property (@(posedge clk) disable iff (rst)
        (dec.stat_we && wdata[1] && !set_second) |=> !stat.second);

    assert_first_set_R5: assert property (@(posedge clk) disable iff (rst)
        set_first |=> stat.first);

    assert_second_set_R6: assert property (@(posedge clk) disable iff (rst)
        set_second |=> stat.second);

endmodule

// File: rtl/wdt2_rst_pulse.sv
module wdt2_rst_pulse #(
    parameter int PULSE_CLKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_CLKS + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_CLKS);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                 left_q <= '0;
        else if (fire)           left_q <= LOAD;
        else if (left_q != '0)   left_q <= left_q - PW'(1);
    end

    assign pulse = (left_q != '0);

    assert_pulse_start_R7: assert property (@(posedge clk) disable iff (rst)
        fire |=> pulse);

    assert_pulse_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (!fire && left_q == PW'(1)) |=> !pulse);

endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog
    import wdt2_pkg::*;
#(
    parameter int CNT_W          = 24,
    parameter int RST_PULSE_CLKS = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_in,
    output logic              irq_o,
    output logic              mod_rst_o
);
    ctrl_t            ctrl;
    stat_t            stat;
    logic [CNT_W-1:0] init_val;
    logic [CNT_W-1:0] count;
    logic             kick;
    logic             tick;
    logic             first_exp;
    logic             second_exp;
    logic             rst_fire;

    wdt2_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .tick_async (tick_in),
        .tick_pulse (tick)
    );

    wdt2_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .set_first  (first_exp),
        .set_second (second_exp),
        .count      (count),
        .ctrl       (ctrl),
        .stat       (stat),
        .init_val   (init_val),
        .kick       (kick),
        .rdata      (bus_rdata)
    );

    wdt2_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .run        (ctrl.run),
        .kick       (kick),
        .init_val   (init_val),
        .count      (count),
        .first_exp  (first_exp),
        .second_exp (second_exp)
    );

    assign rst_fire = second_exp && ctrl.auto_rst;

    wdt2_rst_pulse #(.PULSE_CLKS(RST_PULSE_CLKS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (rst_fire),
        .pulse (mod_rst_o)
    );

    assign irq_o = stat.first | (stat.second & ~ctrl.auto_rst);

    // a first-stage expiry raises the interrupt on the next cycle (R5)
    assert_first_irq_R5: assert property (@(posedge clk) disable iff (rst)
        first_exp |=> irq_o);

    // with auto-reset on, a second-stage expiry resets instead of interrupting (R7)
    assert_auto_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (second_exp && ctrl.auto_rst) |=> mod_rst_o);

    // nothing changes state while stopped and not kicked (R2)
    assert_no_flag_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run |-> !(first_exp || second_exp));

endmodule

// File: tb/dual_stage_watchdog_tb.sv
module dual_stage_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        tick_in;
    logic        irq_o;
    logic        mod_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    bit        m_run, m_auto, m_post, m_stage, m_tmf, m_stf;
    bit [23:0] m_init, m_cnt;

    int hi_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (mod_rst_o) hi_cnt++;

    dual_stage_watchdog #(.RST_PULSE_CLKS(PULSE)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_in   (tick_in),
        .irq_o     (irq_o),
        .mod_rst_o (mod_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit m_tick();
        bit r = 0;
        if (!m_run) return 0;
        if (m_cnt <= 1) begin
            m_cnt = m_init;
            if (!m_stage) begin
                m_stage = 1;
                m_tmf   = 1;
            end else begin
                m_stf = 1;
                r     = m_auto;
            end
        end else begin
            m_cnt = m_cnt - 1;
        end
        return r;
    endfunction

    function automatic bit m_irq();
        return m_tmf | (m_stf & ~m_auto);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        case (a)
            8'h00: begin m_run = d[0]; m_auto = d[1]; m_post = d[2]; end
            8'h04: m_init = d[23:0];
            8'h08: begin m_cnt = m_init; m_stage = 0; end
            8'h0C: begin
                if (d[0]) m_tmf = 0;
                if (d[1]) m_stf = 0;
            end
            8'h80: if (m_post) begin m_cnt = m_init; m_stage = 0; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input string req);
        bit exp_rst;
        tick_in = 1'b1;
        repeat (4) @(negedge clk);
        exp_rst = m_tick();
        chk(req, {31'b0, mod_rst_o}, {31'b0, exp_rst});
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(8'h08, v); chk(req, v, {8'b0, m_cnt});
        rd(8'h0C, v); chk(req, v, {30'b0, m_stf, m_tmf});
        chk(req, {31'b0, irq_o}, {31'b0, m_irq()});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; tick_in = 1'b0;
        {m_run, m_auto, m_post, m_stage, m_tmf, m_stf} = '0;
        m_init = '0; m_cnt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h04, v); chk("R1 init", v, 0);
        rd(8'h08, v); chk("R1 count", v, 0);
        rd(8'h0C, v); chk("R1 status", v, 0);
        chk("R1 irq", {31'b0, irq_o}, 0);
        chk("R1 rst", {31'b0, mod_rst_o}, 0);
        tick("R1 no count");
        check_all("R1 idle");

        // R9: readback
        wr(8'h04, 32'hABCD_EF12);
        rd(8'h04, v); chk("R9 init 24b", v, 32'h00CD_EF12);
        wr(8'h04, 32'h00FF_FFFF);
        rd(8'h04, v); chk("R9 init max", v, 32'h00FF_FFFF);
        wr(8'h00, 32'hFFFF_FFFE);
        rd(8'h00, v); chk("R9 ctrl", v, 32'h6);
        wr(8'h00, 32'h0);

        // R3: kick while stopped loads
        wr(8'h04, 32'd5);
        wr(8'h08, 32'h1234_5678);
        rd(8'h08, v); chk("R3 kick load", v, 32'd5);

        // R2: stopped holds
        tick("R2 stopped");
        check_all("R2 stopped hold");
        // R2: running decrements
        wr(8'h00, 32'h1);
        tick("R2 run");
        check_all("R2 decrement");

        // R4: POST-port write ignored when disabled
        tick("R4 pre");
        wr(8'h80, 32'h0);
        rd(8'h08, v); chk("R4 post ignored", v, 32'd3);
        wr(8'h00, 32'h5);
        wr(8'h80, 32'hFF);
        rd(8'h08, v); chk("R4 post kick", v, 32'd5);

        // R5: first expiry
        repeat (5) tick("R5 tick");
        check_all("R5 first expiry");
        chk("R5 irq", {31'b0, irq_o}, 1);

        // R6: second expiry, irq path
        wr(8'h0C, 32'h1);
        check_all("R8 w1c first");
        repeat (5) tick("R6 tick");
        check_all("R6 second expiry");
        chk("R6 irq", {31'b0, irq_o}, 1);

        // R8: write zero leaves flag, write one clears
        wr(8'h0C, 32'h0);
        check_all("R8 w0 keeps");
        wr(8'h0C, 32'h2);
        check_all("R8 w1c second");

        // R11: later expiries stay second stage
        repeat (5) tick("R11 tick");
        check_all("R11 stays second");
        wr(8'h0C, 32'h3);

        // R10: kick after first expiry restarts stage
        wr(8'h04, 32'd1);
        wr(8'h08, 32'd0);
        tick("R10 first");
        wr(8'h0C, 32'h1);
        wr(8'h08, 32'd0);
        tick("R10 first again");
        check_all("R10 stage reset");
        wr(8'h0C, 32'h3);

        // R7: auto-reset pulse width and no irq
        wr(8'h00, 32'h3);
        wr(8'h08, 32'd0);
        tick("R7 first");
        wr(8'h0C, 32'h1);
        hi_cnt = 0;
        tick("R7 second");
        repeat (10) @(negedge clk);
        chk("R7 pulse width", hi_cnt, PULSE);
        check_all("R7 no irq");
        wr(8'h0C, 32'h3);

        // R5/R0-value: reload of zero expires every tick
        wr(8'h04, 32'd0);
        wr(8'h00, 32'h1);
        wr(8'h08, 32'd0);
        tick("R5 zero reload");
        check_all("R5 zero reload");
        wr(8'h0C, 32'h3);

        // randomized mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 10;
            case (op)
                0, 1, 2, 3: tick("R2/R5/R6/R7 rand tick");
                4: wr(8'h08, $urandom);
                5: wr(8'h80, $urandom);
                6: wr(8'h00, {29'b0, 3'($urandom)});
                7: wr(8'h04, 32'($urandom % 7));
                8: wr(8'h0C, {30'b0, 2'($urandom)});
                default: check_all("R3/R4/R10/R11 rand state");
            endcase
            chk("R8 rand irq", {31'b0, irq_o}, {31'b0, m_irq()});
        end
        check_all("R9 final");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule